// File: doc/BRIEF.md
# Digitally Trimmed Seconds Prescaler

The block turns a free-running 32,768 Hz crystal clock into a one-cycle-wide seconds tick. Instead of pulling the oscillator, it corrects the rate by occasionally altering the length of a single second. A 5-bit magnitude and a direction bit choose how many minutes of a repeating 64-minute correction window carry one altered second. A positive direction makes the altered second shorter, so the clock runs faster. A negative direction makes it longer, so the clock runs slower.

The divider is a free-running half-stage counter of 128 input cycles. A second counter counts half-stage pulses. The correction removes two half-stage pulses from a second, which takes 256 cycles off it. It adds one half-stage pulse to lengthen a second, which puts 128 cycles on it. A stop control freezes the whole divider, and counting resumes from the frozen point when it is released. A frequency-test enable drives a 512 Hz square wave taken from the half-stage counter. Because that counter is never touched by the correction, the test wave is independent of the trim setting.

The seconds-in-minute and minute-in-window counters are internal. Calendar counting and register access are left to the surrounding logic, which only has to hold the magnitude, direction, stop and test bits.

Top module: `rtc_trim_prescaler`

## Requirements
- R1: While reset is low, both outputs are low. After reset is released with a zero magnitude, the first tick appears in the 32,768th input cycle counted from the release cycle. The release cycle is the first cycle in which reset is sampled high.
- R2: Without correction, a second is 32,768 input cycles from one tick to the next. The tick is high for exactly one input cycle.
- R3: With the direction bit at 1, an altered second is 256 input cycles shorter than normal.
- R4: With the direction bit at 0, an altered second is 128 input cycles longer than normal.
- R5: The minute and window counters start at zero on reset. Only the first second of a minute is ever altered. With magnitude N, it is altered in minutes 0 to 2N-1 of each 64-minute window, and the pattern repeats every window.
- R6: Minutes 62 and 63 of a window are never altered. A magnitude of 31 therefore alters exactly 62 seconds per window.
- R7: Magnitude and direction are sampled during reset and at each minute boundary only. A change made mid-minute first acts on the first second of the next minute.
- R8: While stop is 1, no tick is issued, the test output is low, and the divider holds its count. After stop returns to 0, counting resumes from the held count, so the next tick comes within one second.
- R9: When test-enable is 1 and stop is 0, the test output is a square wave of period 64 input cycles with a 50% duty cycle. When test-enable is 0, the test output is low.
- R10: The phase and period of the test wave do not depend on the magnitude or direction. This holds across altered seconds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crystal-rate input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stop_i | input | 1 | 1 freezes the divider |
| freq_test_i | input | 1 | 1 enables the test square wave |
| cal_mag_i | input | MAG_W (5) | Correction magnitude, 0 to 31 |
| cal_pos_i | input | 1 | Correction direction: 1 shortens seconds, 0 lengthens them |
| tick_1hz_o | output | 1 | One-cycle pulse that ends each second |
| test_wave_o | output | 1 | 512 Hz test square wave |

## Verification
The assertions assume that the magnitude and direction change only between clock edges and are treated as static register values. They also assume that stop may be asserted in any cycle, including the tick cycle, and that every second is long enough to hold more than one half-stage pulse. The stimulus changes its inputs only one nanosecond after a falling edge, so they are stable at every rising edge. It covers zero, small and maximum magnitudes in both directions, a magnitude change in the middle of a minute, and stop windows placed inside a second. The bench shrinks the dividers and the seconds-per-minute count through parameters so that complete 64-minute windows fit in the run.

// File: rtl/rtc_trim_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the trimmed seconds prescaler.
// Assumes: nothing beyond SystemVerilog 2017.
package rtc_trim_pkg;
    // Length class of the second currently being counted.
    typedef enum logic [1:0] {
        SEC_NORMAL = 2'd0,
        SEC_SHORT  = 2'd1,
        SEC_LONG   = 2'd2
    } sec_mode_e;
endpackage

// File: rtl/rtc_half_divider.sv
`timescale 1ns/1ps
// Module: rtc_half_divider
// Free-running half-stage counter. It emits one pulse every 2**PRE_W
// running cycles and exposes a bit used as the test square wave.
// Assumes: TEST_DIV_W <= PRE_W. The correction never alters this counter.
module rtc_half_divider #(
    parameter int PRE_W      = 7,
    parameter int TEST_DIV_W = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic half_pulse,
    output logic test_phase
);
    localparam int TEST_BIT = TEST_DIV_W - 1;

    logic [PRE_W-1:0] pre_q;

    // Advance the half-stage count whenever the divider runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (run) begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // Pulse on the last count of each half stage, only while running.
    always_comb begin
        half_pulse = run && (&pre_q);
        test_phase = pre_q[TEST_BIT];
    end
endmodule

// File: rtl/rtc_second_counter.sv
`timescale 1ns/1ps
// Module: rtc_second_counter
// Counts half-stage pulses and ends the second at a terminal count that
// depends on the length class: normal, two pulses short, or one pulse long.
// Assumes: HALF_W >= 2. The mode only changes on a tick edge.
module rtc_second_counter
    import rtc_trim_pkg::*;
#(
    parameter int HALF_W = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      half_pulse,
    input  sec_mode_e mode,
    output logic      tick
);
    localparam int CNT_W     = HALF_W + 1;
    localparam int NORM_HALF = 2 ** HALF_W;

    localparam logic [CNT_W-1:0] LAST_NORM  = CNT_W'(NORM_HALF - 1);
    localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(NORM_HALF - 3);
    localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(NORM_HALF);

    logic [CNT_W-1:0] half_q;
    logic [CNT_W-1:0] last_cnt;

    // Select the terminal half-pulse count for the current second.
    always_comb begin
        case (mode)
            SEC_SHORT: last_cnt = LAST_SHORT;
            SEC_LONG:  last_cnt = LAST_LONG;
            default:   last_cnt = LAST_NORM;
        endcase
    end

    // The second ends on the half pulse that reaches the terminal count.
    always_comb begin
        tick = half_pulse && (half_q == last_cnt);
    end

    // Count half pulses within the second and restart after the tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q <= '0;
        end else if (tick) begin
            half_q <= '0;
        end else if (half_pulse) begin
            half_q <= half_q + 1'b1;
        end
    end
endmodule

// File: rtl/rtc_trim_sequencer.sv
`timescale 1ns/1ps
// Module: rtc_trim_sequencer
// Tracks the second within the minute and the minute within the correction
// window. It picks the length class of each new second, sampling the
// magnitude and direction in reset and at minute boundaries only.
// Assumes: SECS_PER_MIN >= 1 and ELIGIBLE_MIN <= CYCLE_MIN.
module rtc_trim_sequencer
    import rtc_trim_pkg::*;
#(
    parameter int SECS_PER_MIN = 60,
    parameter int CYCLE_MIN    = 64,
    parameter int ELIGIBLE_MIN = 62,
    parameter int MAG_W        = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [MAG_W-1:0] cal_mag,
    input  logic             cal_pos,
    output sec_mode_e        mode
);
    localparam int SEC_W = $clog2(SECS_PER_MIN + 1);
    localparam int MIN_W = $clog2(CYCLE_MIN + 1);
    localparam int CMP_W = ((MIN_W > MAG_W + 1) ? MIN_W : MAG_W + 1) + 1;

    localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(SECS_PER_MIN - 1);
    localparam logic [MIN_W-1:0] MIN_LAST = MIN_W'(CYCLE_MIN - 1);
    localparam logic [CMP_W-1:0] ELIG_LIM = CMP_W'(ELIGIBLE_MIN);

    logic [SEC_W-1:0] sec_q;
    logic [MIN_W-1:0] min_q;
    logic             sec_wrap;
    logic [SEC_W-1:0] sec_nx;
    logic [MIN_W-1:0] min_nx;
    logic [MIN_W-1:0] cand_min;
    logic             cand_first;
    logic [CMP_W-1:0] cand_ext;
    logic [CMP_W-1:0] mag_lim;
    sec_mode_e        mode_nx;

    // Next second and minute indices on a tick.
    always_comb begin
        sec_wrap = (sec_q == SEC_LAST);
        sec_nx   = sec_wrap ? '0 : sec_q + 1'b1;
        if (!sec_wrap) begin
            min_nx = min_q;
        end else if (min_q == MIN_LAST) begin
            min_nx = '0;
        end else begin
            min_nx = min_q + 1'b1;
        end
    end

    // Length class of the upcoming second; reset behaves as minute 0 start.
    always_comb begin
        cand_min   = rst_n ? min_nx : '0;
        cand_first = rst_n ? sec_wrap : 1'b1;
        cand_ext   = CMP_W'(cand_min);
        mag_lim    = CMP_W'({cal_mag, 1'b0});
        if (cand_first && (cand_ext < mag_lim) && (cand_ext < ELIG_LIM)) begin
            mode_nx = cal_pos ? SEC_SHORT : SEC_LONG;
        end else begin
            mode_nx = SEC_NORMAL;
        end
    end

    // Step the position counters and latch the class at each second start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q <= '0;
            min_q <= '0;
            mode  <= mode_nx;
        end else if (tick) begin
            sec_q <= sec_nx;
            min_q <= min_nx;
            mode  <= mode_nx;
        end
    end
endmodule

// File: rtl/rtc_trim_prescaler.sv
`timescale 1ns/1ps
// Module: rtc_trim_prescaler (top)
// Divides the crystal clock to a one-cycle seconds tick. The rate is
// trimmed by shortening or stretching the first second of selected minutes
// in a repeating correction window. Also drives a gated test square wave.
// Assumes: control inputs are static register bits, synchronous to clk.
module rtc_trim_prescaler
    import rtc_trim_pkg::*;
#(
    parameter int PRE_W        = 7,
    parameter int HALF_W       = 8,
    parameter int TEST_DIV_W   = 6,
    parameter int SECS_PER_MIN = 60,
    parameter int CYCLE_MIN    = 64,
    parameter int ELIGIBLE_MIN = 62,
    parameter int MAG_W        = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop_i,
    input  logic             freq_test_i,
    input  logic [MAG_W-1:0] cal_mag_i,
    input  logic             cal_pos_i,
    output logic             tick_1hz_o,
    output logic             test_wave_o
);
    logic      run;
    logic      half_pulse;
    logic      test_phase;
    sec_mode_e sec_mode;

    // The divider advances only while not stopped.
    always_comb begin
        run = !stop_i;
    end

    rtc_half_divider #(
        .PRE_W      (PRE_W),
        .TEST_DIV_W (TEST_DIV_W)
    ) u_half (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .half_pulse (half_pulse),
        .test_phase (test_phase)
    );

    rtc_second_counter #(
        .HALF_W     (HALF_W)
    ) u_sec (
        .clk        (clk),
        .rst_n      (rst_n),
        .half_pulse (half_pulse),
        .mode       (sec_mode),
        .tick       (tick_1hz_o)
    );

    rtc_trim_sequencer #(
        .SECS_PER_MIN (SECS_PER_MIN),
        .CYCLE_MIN    (CYCLE_MIN),
        .ELIGIBLE_MIN (ELIGIBLE_MIN),
        .MAG_W        (MAG_W)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_1hz_o),
        .cal_mag (cal_mag_i),
        .cal_pos (cal_pos_i),
        .mode    (sec_mode)
    );

    // Test wave is driven only when enabled and the divider is running.
    always_comb begin
        test_wave_o = freq_test_i && run && test_phase;
    end
endmodule

// File: rtl/rtc_trim_checker.sv
`timescale 1ns/1ps
// Module: rtc_trim_checker
// Temporal checks for the trimmed prescaler, bound into the top module.
// Assumes: inputs change only between rising edges.
module rtc_trim_checker
    import rtc_trim_pkg::*;
#(
    parameter int PRE_W        = 7,
    parameter int HALF_W       = 8,
    parameter int SECS_PER_MIN = 60
) (
    input logic      clk,
    input logic      rst_n,
    input logic      stop_i,
    input logic      freq_test_i,
    input logic      tick_1hz_o,
    input logic      test_wave_o,
    input sec_mode_e sec_mode
);
    localparam int NORM_LEN  = 2 ** (PRE_W + HALF_W);
    localparam int SHORT_LEN = NORM_LEN - 2 ** (PRE_W + 1);
    localparam int LONG_LEN  = NORM_LEN + 2 ** PRE_W;

    logic [31:0] run_cnt;
    logic [31:0] want_len;

    // Running cycles since reset or the last tick.
    always_ff @(posedge clk) begin
        if (!rst_n || tick_1hz_o) begin
            run_cnt <= '0;
        end else if (!stop_i) begin
            run_cnt <= run_cnt + 1;
        end
    end

    // Expected second length for the current class.
    always_comb begin
        case (sec_mode)
            SEC_SHORT: want_len = 32'(SHORT_LEN);
            SEC_LONG:  want_len = 32'(LONG_LEN);
            default:   want_len = 32'(NORM_LEN);
        endcase
    end

    assert_tick_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_1hz_o |=> !tick_1hz_o);

    assert_second_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick_1hz_o |-> (run_cnt + 1 == want_len));  // also R4, R8

    assert_stop_no_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |-> !tick_1hz_o);

    assert_test_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!freq_test_i || stop_i) |-> !test_wave_o);

    assert_class_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_1hz_o |=> $stable(sec_mode));

    generate
        if (SECS_PER_MIN > 1) begin : g_multi_sec
            assert_no_back_to_back_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (tick_1hz_o && sec_mode != SEC_NORMAL) |=> sec_mode == SEC_NORMAL);
        end
    endgenerate
endmodule

bind rtc_trim_prescaler rtc_trim_checker #(
    .PRE_W        (PRE_W),
    .HALF_W       (HALF_W),
    .SECS_PER_MIN (SECS_PER_MIN)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .stop_i      (stop_i),
    .freq_test_i (freq_test_i),
    .tick_1hz_o  (tick_1hz_o),
    .test_wave_o (test_wave_o),
    .sec_mode    (sec_mode)
);

// File: tb/rtc_trim_prescaler_tb.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared on every falling edge, plus
// directed measurements of second lengths and test-wave timing.
// Dividers are shrunk: half stage 8 cycles, second 64, minute 3 seconds.
module rtc_trim_prescaler_tb;
    localparam int PRE_W = 3, HALF_W = 3, TDW = 3, SPM = 3, CYM = 64, ELIG = 62;
    localparam int NORM = 2 ** (PRE_W + HALF_W);
    localparam int SHRT = NORM - 2 ** (PRE_W + 1);
    localparam int LNG  = NORM + 2 ** PRE_W;

    logic clk = 1'b0, rst_n = 1'b0, stop = 1'b0, ft = 1'b0, pos = 1'b0;
    logic [4:0] mag = '0;
    logic tick, tw;
    int runs = 0, fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    rtc_trim_prescaler #(
        .PRE_W(PRE_W), .HALF_W(HALF_W), .TEST_DIV_W(TDW), .SECS_PER_MIN(SPM),
        .CYCLE_MIN(CYM), .ELIGIBLE_MIN(ELIG), .MAG_W(5)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .stop_i(stop), .freq_test_i(ft),
        .cal_mag_i(mag), .cal_pos_i(pos), .tick_1hz_o(tick), .test_wave_o(tw)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        runs++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
        end
    endtask

    // Reference model: position, second, minute, class, test phase.
    int m_pos, m_sec, m_min, m_mode, m_tc;
    function automatic int mlen(input int md);
        return (md == 1) ? SHRT : (md == 2) ? LNG : NORM;
    endfunction
    function automatic int mpick(input int mn);
        return (mn < 2 * int'(mag) && mn < ELIG) ? (pos ? 1 : 2) : 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pos = 0; m_sec = 0; m_min = 0; m_tc = 0; m_mode = mpick(0);
        end else if (!stop) begin
            m_tc++;
            if (m_pos == mlen(m_mode) - 1) begin
                m_pos = 0;
                if (m_sec == SPM - 1) begin
                    m_sec = 0; m_min = (m_min + 1) % CYM; m_mode = mpick(m_min);
                end else begin
                    m_sec++; m_mode = 0;
                end
            end else m_pos++;
        end
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(tick === (!stop && m_pos == mlen(m_mode) - 1), "R2/R5 tick vs model",
                int'(tick), int'(!stop && m_pos == mlen(m_mode) - 1));
            chk(tw === (ft && !stop && ((m_tc >> (TDW - 1)) & 1) == 1), "R9 test wave vs model",
                int'(tw), int'(ft && !stop && ((m_tc >> (TDW - 1)) & 1) == 1));
        end
    end

    task automatic do_reset(input int mg, input bit ps);
        @(negedge clk); #1;
        rst_n = 1'b0; mag = 5'(mg); pos = ps; stop = 1'b0; ft = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk(tick == 1'b0 && tw == 1'b0, "R1 outputs low in reset", int'({tick, tw}), 0);
        end
        #1 rst_n = 1'b1;
    endtask

    // Running falling edges up to and including the next tick.
    task automatic wait_tick(output int n);
        n = 0;
        do begin
            @(negedge clk);
            if (!stop) n++;
        end while (!tick);
    endtask

    int n;
    initial begin
        // R1 / R2: plain second lengths.
        do_reset(0, 0);
        wait_tick(n); chk(n == NORM - 1, "R1 first tick after release", n, NORM - 1);
        wait_tick(n); chk(n == NORM, "R2 uncorrected second", n, NORM);

        // R3 / R5: magnitude 1 positive, first minute pattern.
        do_reset(1, 1);
        wait_tick(n); chk(n == SHRT - 1, "R3 shortened first second", n, SHRT - 1);
        for (int i = 1; i < 9; i++) begin
            int e;
            e = (i == 3) ? SHRT : NORM;
            wait_tick(n); chk(n == e, "R5 minute pattern mag 1", n, e);
        end

        // R4: negative direction lengthens.
        do_reset(1, 0);
        wait_tick(n); chk(n == LNG - 1, "R4 lengthened first second", n, LNG - 1);
        wait_tick(n); chk(n == NORM, "R4 second after lengthened", n, NORM);

        // R6 / R5: magnitude 31 over a full window, then the window repeats.
        do_reset(31, 1);
        begin
            int shorts = 0;
            for (int i = 0; i < SPM * CYM; i++) begin
                wait_tick(n);
                if (n == SHRT || (i == 0 && n == SHRT - 1)) shorts++;
            end
            chk(shorts == ELIG, "R6 altered seconds per window", shorts, ELIG);
        end
        wait_tick(n); chk(n == SHRT, "R5 window restarts at minute 0", n, SHRT);

        // R7: mid-minute change waits for the next minute boundary.
        do_reset(0, 0);
        wait_tick(n);
        #1 mag = 5'd2; pos = 1'b1;
        wait_tick(n); chk(n == NORM, "R7 change ignored mid-minute", n, NORM);
        wait_tick(n); chk(n == NORM, "R7 change ignored mid-minute", n, NORM);
        wait_tick(n); chk(n == SHRT, "R7 change applied at next minute", n, SHRT);

        // R8: stop freezes and resumes from the held count.
        do_reset(0, 0);
        repeat (20) @(negedge clk);
        #1 stop = 1'b1; ft = 1'b1;
        repeat (50) begin
            @(negedge clk);
            chk(tick == 1'b0 && tw == 1'b0, "R8 frozen while stopped", int'({tick, tw}), 0);
        end
        #1 stop = 1'b0;
        wait_tick(n); chk(n == NORM - 1 - 20, "R8 resume from held count", n, NORM - 21);

        // R9: test wave period and duty.
        begin
            int hi = 0, rises = 0;
            logic prev;
            prev = tw;
            for (int i = 0; i < 64; i++) begin
                @(negedge clk);
                if (tw) hi++;
                if (tw && !prev) rises++;
                prev = tw;
            end
            chk(hi == 32, "R9 duty cycle", hi, 32);
            chk(rises == 64 / 2 ** TDW, "R9 period", rises, 64 / 2 ** TDW);
            #1 ft = 1'b0;
            repeat (20) @(negedge clk);
            chk(tw == 1'b0, "R9 low when disabled", int'(tw), 0);
        end

        // R10: test wave spacing unchanged across altered seconds.
        do_reset(31, 0);
        #1 ft = 1'b1;
        begin
            int last = -1, bad = 0;
            logic prev;
            prev = 1'b0;
            for (int i = 0; i < 600; i++) begin
                @(negedge clk);
                if (tw && !prev) begin
                    if (last >= 0 && i - last != 2 ** TDW) bad++;
                    last = i;
                end
                prev = tw;
            end
            chk(bad == 0, "R10 test spacing ignores trim", bad, 0);
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1;
            runs++; fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  [TB] %0d tests run, %0d failed", runs, fails);
            $finish;
        end
    end
endmodule